// File: doc/BRIEF.md
# Dual-Line Serial Lock Register Target

This block is the command front end of a serial memory target. It talks to its host over two data lines, named DQ1 and DQ0 here, and it moves two bits on every serial clock in every phase, opcode included. It serves three commands. A write-enable command sets a latch. A lock read returns one byte of a small bank of 8-bit lock registers. A lock write changes one such byte, and only when the latch was set beforehand. The address that follows a read or write opcode selects the register.

The two data lines are presented at the pad boundary as input, output and output-enable signals. Index 1 of each bus is DQ1 and index 0 is DQ0, and a pad buffer outside the block joins them into bidirectional pins. Input bits are sampled on the rising serial clock edge and output bits change on the falling edge. Any rise of chip select ends the command under way. A complete write or write-enable takes effect at that rise.

Top module: `dio_lockreg_target`

## Requirements
- R1: After reset the output enable is low, every lock register reads as 8'h00 and the write-enable latch is clear.
- R2: The 8-bit opcode arrives over 4 rising clock edges, MSB first, two bits per edge with the odd bit on DQ1 (`dq_in[1]`) and the next lower even bit on DQ0 (`dq_in[0]`). By default 8'hE8 is the lock read, 8'hE5 the lock write and 8'h06 the write enable. Any other opcode is ignored.
- R3: A 24-bit address follows a read or write opcode over 12 rising edges in the same layout (bits 23/22 first, 1/0 last). Address bits [23:16] select the register and the lower 16 bits have no effect.
- R4: After the 16th rising edge of a read, each falling edge drives the next bit pair of the selected byte, MSB first: DQ1/DQ0 carry 7/6, then 5/4, 3/2 and 1/0.
- R5: While chip select stays low, the same byte is sent again and again with no gap.
- R6: `dq_oe` is high only during the data-out phase of a read and is low whenever chip select is high.
- R7: A lock write changes the selected register only when the write-enable latch is set. Otherwise the register keeps its value.
- R8: A write commits only when chip select rises right after the 20th rising edge (4 opcode, 12 address, 4 data). A session with fewer or more edges changes no register and leaves the latch as it was.
- R9: A committed write attempt clears the write-enable latch whether or not a register changed. A later write without a new write enable is refused.
- R10: A selector of NUM_REGS or above reads as 8'h00, and a write to it changes no register.
- R11: The write-enable latch is set only when chip select rises right after exactly the 4 opcode edges of the write-enable command.
- R12: A chip select rise at any point abandons the command. The next session starts again at the opcode phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its rise ends a command |
| sclk | input | 1 | Serial clock, idle low |
| dq_in | input | 2 | Data lines as received from the pads: [1] DQ1, [0] DQ0 |
| dq_out | output | 2 | Data lines to drive: [1] DQ1, [0] DQ0 |
| dq_oe | output | 1 | Output enable for both data lines |

## Verification
A slip in the bit counter or in the phase sequence shows up at the ports on the first read after the faulty command. The bytes come out shifted, swapped in their bit pairs, or taken from the wrong register, and the sweep of all 256 data values across the bank catches that at once. A latch left in the wrong state shows up in the very next write: a refused write reads back unchanged, or a write that should land does not. The bench therefore follows every latch-related session with a write-and-read pair. Errors in the commit boundary only appear when chip select rises one edge early or late, so those boundaries are driven on purpose.

// File: rtl/dlr_pkg.sv
package dlr_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADR,
    PH_DIN,
    PH_DOUT,
    PH_FULL,
    PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_RD,
    CMD_WR,
    CMD_WE
  } cmd_e;

endpackage

// File: rtl/dlr_rx.sv
module dlr_rx
  import dlr_pkg::*;
#(
  parameter logic [7:0] OPC_RD = 8'hE8,
  parameter logic [7:0] OPC_WR = 8'hE5,
  parameter logic [7:0] OPC_WE = 8'h06,
  parameter int         ADDR_W = 24,
  parameter int         SEL_W  = 8
) (
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [1:0]       dq_in,
  output phase_e           phase_o,
  output cmd_e             cmd_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [7:0]       wdata_o,
  output logic             seq_o
);

  localparam int OPC_PAIRS = 4;
  localparam int ADR_PAIRS = ADDR_W / 2;
  localparam int DAT_PAIRS = 4;
  localparam int CNT_W     = $clog2(ADR_PAIRS + 1);

  logic             sess_rst_n;
  logic             sess_q;
  phase_e           phase_q, phase_d, ph;
  cmd_e             cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cn;
  logic [ADDR_W-1:0] sr_q, sr_d, sr;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             seq_q, seq_d;
  logic             sr_en;

  // session marker: cleared while chip select is high
  assign sess_rst_n = rst_n & ~cs_n;

  always_ff @(posedge sclk or negedge sess_rst_n) begin
    if (!sess_rst_n) sess_q <= 1'b0;
    else             sess_q <= 1'b1;
  end

  // first edge of a session restarts from the opcode phase
  always_comb begin
    ph      = sess_q ? phase_q : PH_OPC;
    cn      = sess_q ? cnt_q : '0;
    sr      = sess_q ? sr_q : '0;
    sr_d    = {sr[ADDR_W-3:0], dq_in};
    cnt_d   = cn + 1'b1;
    phase_d = ph;
    cmd_d   = cmd_q;
    sel_d   = sel_q;
    seq_d   = sess_q ? seq_q : ~seq_q;
    sr_en   = (ph == PH_OPC) || (ph == PH_ADR) || (ph == PH_DIN);
    unique case (ph)
      PH_OPC: begin
        if (cn == CNT_W'(OPC_PAIRS - 1)) begin
          cnt_d = '0;
          if (sr_d[7:0] == OPC_RD) begin
            cmd_d = CMD_RD; phase_d = PH_ADR;
          end else if (sr_d[7:0] == OPC_WR) begin
            cmd_d = CMD_WR; phase_d = PH_ADR;
          end else if (sr_d[7:0] == OPC_WE) begin
            cmd_d = CMD_WE; phase_d = PH_FULL;
          end else begin
            cmd_d = CMD_NONE; phase_d = PH_SKIP;
          end
        end
      end
      PH_ADR: begin
        if (cn == CNT_W'(ADR_PAIRS - 1)) begin
          cnt_d   = '0;
          sel_d   = sr_d[ADDR_W-1 -: SEL_W];
          phase_d = (cmd_q == CMD_RD) ? PH_DOUT : PH_DIN;
        end
      end
      PH_DIN: begin
        if (cn == CNT_W'(DAT_PAIRS - 1)) begin
          cnt_d   = '0;
          phase_d = PH_FULL;
        end
      end
      PH_FULL: begin
        cnt_d   = cn;
        phase_d = PH_SKIP;
      end
      default: cnt_d = cn;
    endcase
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC;
      cmd_q   <= CMD_NONE;
      cnt_q   <= '0;
      sr_q    <= '0;
      sel_q   <= '0;
      seq_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      seq_q   <= seq_d;
      if (sr_en) sr_q <= sr_d;
    end
  end

  assign phase_o = phase_q;
  assign cmd_o   = cmd_q;
  assign sel_o   = sel_q;
  assign wdata_o = sr_q[7:0];
  assign seq_o   = seq_q;

endmodule

// File: rtl/dlr_tx.sv
module dlr_tx
  import dlr_pkg::*;
(
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  phase_e     rx_phase,
  input  logic [7:0] rd_byte,
  output logic [1:0] dq_out,
  output logic       dq_oe
);

  logic       sess_rst_n;
  logic       oe_q, oe_d;
  logic [1:0] out_q, out_d;
  logic [7:0] rot_q, rot_d;
  logic       upd;

  assign sess_rst_n = rst_n & ~cs_n;
  assign upd        = (rx_phase == PH_DOUT);

  always_comb begin
    oe_d  = 1'b1;
    if (!oe_q) begin
      out_d = rd_byte[7:6];
      rot_d = {rd_byte[5:0], rd_byte[7:6]};
    end else begin
      out_d = rot_q[7:6];
      rot_d = {rot_q[5:0], rot_q[7:6]};
    end
  end

  always_ff @(negedge sclk or negedge sess_rst_n) begin
    if (!sess_rst_n) begin
      oe_q  <= 1'b0;
      out_q <= '0;
      rot_q <= '0;
    end else if (upd) begin
      oe_q  <= oe_d;
      out_q <= out_d;
      rot_q <= rot_d;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = oe_q;

endmodule

// File: rtl/dlr_bank.sv
module dlr_bank
  import dlr_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = 8
) (
  input  logic             rst_n,
  input  logic             cs_n,
  input  phase_e           rx_phase,
  input  cmd_e             rx_cmd,
  input  logic [SEL_W-1:0] rx_sel,
  input  logic [7:0]       rx_wdata,
  input  logic             rx_seq,
  output logic [7:0]       rd_byte,
  output logic             wel_o
);

  logic [NUM_REGS-1:0][7:0] lock_q;
  logic [NUM_REGS-1:0]      wr_en;
  logic                     wel_q, wel_d;
  logic                     seen_q;
  logic                     done, we_set, wr_try;

  // a session with no clocks leaves the sequence bit untouched
  assign done   = (rx_seq != seen_q) && (rx_phase == PH_FULL);
  assign we_set = done && (rx_cmd == CMD_WE);
  assign wr_try = done && (rx_cmd == CMD_WR);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wen
      assign wr_en[g] = wr_try && wel_q && (rx_sel == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    wel_d = wel_q;
    if (we_set)      wel_d = 1'b1;
    else if (wr_try) wel_d = 1'b0;
  end

  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      wel_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      seen_q <= rx_seq;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_en[i]) lock_q[i] <= rx_wdata;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rx_sel == SEL_W'(i)) rd_byte = lock_q[i];
    end
  end

  assign wel_o = wel_q;

endmodule

// File: rtl/dio_lockreg_target.sv
module dio_lockreg_target
  import dlr_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter int         ADDR_W   = 24,
  parameter logic [7:0] OPC_RD   = 8'hE8,
  parameter logic [7:0] OPC_WR   = 8'hE5,
  parameter logic [7:0] OPC_WE   = 8'h06
) (
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic [1:0] dq_in,
  output logic [1:0] dq_out,
  output logic       dq_oe
);

  localparam int SEL_W = 8;

  phase_e           rx_phase;
  cmd_e             rx_cmd;
  logic [SEL_W-1:0] rx_sel;
  logic [7:0]       rx_wdata;
  logic             rx_seq;
  logic [7:0]       rd_byte;
  logic             wel;

  dlr_rx #(
    .OPC_RD(OPC_RD), .OPC_WR(OPC_WR), .OPC_WE(OPC_WE),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_rx (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_in(dq_in),
    .phase_o(rx_phase), .cmd_o(rx_cmd), .sel_o(rx_sel),
    .wdata_o(rx_wdata), .seq_o(rx_seq)
  );

  dlr_bank #(
    .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) u_bank (
    .rst_n(rst_n), .cs_n(cs_n), .rx_phase(rx_phase), .rx_cmd(rx_cmd),
    .rx_sel(rx_sel), .rx_wdata(rx_wdata), .rx_seq(rx_seq),
    .rd_byte(rd_byte), .wel_o(wel)
  );

  dlr_tx u_tx (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .rx_phase(rx_phase),
    .rd_byte(rd_byte), .dq_out(dq_out), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/dlr_chk.sv
module dlr_chk
  import dlr_pkg::*;
(
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       dq_oe,
  input logic [1:0] dq_out,
  input phase_e     rx_phase,
  input cmd_e       rx_cmd
);

  // R6
  oe_in_dout_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    dq_oe |-> (rx_phase == PH_DOUT));

  // R6
  oe_idle_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !dq_oe);

  // R5
  byte_repeat_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (dq_oe && $past(dq_oe, 4)) |-> (dq_out == $past(dq_out, 4)));

  // R11
  we_no_addr_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (rx_phase == PH_ADR) |-> (rx_cmd == CMD_RD || rx_cmd == CMD_WR));

  // R4
  dout_read_only_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (rx_phase == PH_DOUT) |-> (rx_cmd == CMD_RD));

endmodule

bind dio_lockreg_target dlr_chk u_chk (
  .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_oe(dq_oe),
  .dq_out(dq_out), .rx_phase(rx_phase), .rx_cmd(rx_cmd)
);

// File: tb/dio_lockreg_target_tb.sv
`timescale 1ns/1ps
module dio_lockreg_target_tb;

  localparam int NREG = 4;

  logic       rst_n, cs_n, sclk;
  logic [1:0] dq_in, dq_out;
  logic       dq_oe;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] model [NREG];

  dio_lockreg_target u_dut (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one rising then one falling edge, 5 ns period
  task automatic pair(input logic [1:0] d);
    dq_in = d;
    #2.5 sclk = 1'b1;
    #2.5 sclk = 1'b0;
  endtask

  task automatic shift_out(input logic [31:0] v, input int npairs);
    for (int i = npairs - 1; i >= 0; i--) pair(v[2*i+1 -: 2]);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    #2.5;
  endtask

  task automatic cs_hi();
    #2.5 cs_n = 1'b1;
    #5;
  endtask

  task automatic wren();
    cs_lo(); shift_out(32'h06, 4); cs_hi();
  endtask

  task automatic wr(input logic [7:0] sel, input logic [7:0] d, input int extra);
    cs_lo();
    shift_out(32'hE5, 4);
    shift_out({8'h00, sel, ~d, d}, 12);
    shift_out({24'h0, d}, 4);
    for (int i = 0; i < extra; i++) pair(2'b11);
    cs_hi();
  endtask

  // reads nb bytes; returns first byte, OR of differences, and early-drive flag
  task automatic rd(input logic [7:0] sel, input int nb, output logic [7:0] b0,
                    output logic [7:0] diff, output logic early);
    logic [7:0] b;
    early = 1'b0; diff = 8'h00; b0 = 8'h00;
    cs_lo();
    for (int i = 3; i >= 0; i--) begin
      pair(8'hE8 >> (2*i)); #1 early |= dq_oe;
    end
    for (int i = 11; i >= 0; i--) begin
      pair({sel, 8'hA5, 8'h3C} >> (2*i));
      #1 if (i != 0) early |= dq_oe;
    end
    for (int n = 0; n < nb; n++) begin
      b = 8'h00;
      for (int k = 0; k < 4; k++) begin
        if (!(n == 0 && k == 0)) pair(2'b00);
        #1 b = {b[5:0], dq_out};
      end
      if (n == 0) b0 = b; else diff |= (b ^ b0);
    end
    cs_hi();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual 00 expected 01");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b, df;
    logic       e;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; dq_in = 2'b00;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    #12 rst_n = 1'b1;
    #5;

    // R1 reset state
    chk("R1 oe", {7'h0, dq_oe}, 8'h00);
    for (int i = 0; i < NREG; i++) begin
      rd(8'(i), 1, b, df, e);
      chk("R1 reg", b, 8'h00);
    end

    // R7 write without enable refused
    wr(8'h00, 8'h5A, 0);
    rd(8'h00, 1, b, df, e);
    chk("R7 no wel", b, 8'h00);

    // R2 R3 R4 sweep every data value across the bank
    for (int v = 0; v < 256; v++) begin
      wren();
      wr(8'(v % NREG), 8'(v), 0);
      model[v % NREG] = 8'(v);
      rd(8'(v % NREG), 1, b, df, e);
      chk("R2 R3 R4 sweep", b, model[v % NREG]);
      if (v < 8) chk("R6 early drive", {7'h0, e}, 8'h00);
    end
    chk("R6 oe after cs", {7'h0, dq_oe}, 8'h00);

    // R5 repeat
    rd(8'h02, 4, b, df, e);
    chk("R5 first", b, model[2]);
    chk("R5 repeat", df, 8'h00);

    // R9 latch cleared by committed write
    wren(); wr(8'h01, 8'hAA, 0); model[1] = 8'hAA;
    wr(8'h01, 8'h55, 0);
    rd(8'h01, 1, b, df, e);
    chk("R9 second write refused", b, 8'hAA);

    // R10 out-of-range selector
    wren(); wr(8'h04, 8'h77, 0);
    rd(8'h04, 1, b, df, e);  chk("R10 read sel 4", b, 8'h00);
    rd(8'hFF, 1, b, df, e);  chk("R10 read sel FF", b, 8'h00);
    for (int i = 0; i < NREG; i++) begin
      rd(8'(i), 1, b, df, e); chk("R10 bank untouched", b, model[i]);
    end
    wr(8'h00, 8'h11, 0);
    rd(8'h00, 1, b, df, e);  chk("R9 R10 latch cleared", b, model[0]);

    // R8 short session: no commit, latch kept
    wren();
    cs_lo(); shift_out(32'hE5, 4); shift_out({8'h00, 8'h03, 16'h0}, 12);
    pair(2'b10); pair(2'b10); cs_hi();
    rd(8'h03, 1, b, df, e);  chk("R8 short", b, model[3]);
    wr(8'h03, 8'hC3, 0); model[3] = 8'hC3;
    rd(8'h03, 1, b, df, e);  chk("R8 latch kept after short", b, 8'hC3);

    // R8 long session: no commit, latch kept
    wren(); wr(8'h02, 8'h99, 1);
    rd(8'h02, 1, b, df, e);  chk("R8 long", b, model[2]);
    wr(8'h02, 8'h66, 0); model[2] = 8'h66;
    rd(8'h02, 1, b, df, e);  chk("R8 latch kept after long", b, 8'h66);

    // R11 write enable with wrong length
    cs_lo(); shift_out(32'h06, 4); pair(2'b00); cs_hi();
    wr(8'h00, 8'h21, 0);
    rd(8'h00, 1, b, df, e);  chk("R11 five edges", b, model[0]);
    cs_lo(); shift_out(32'h06 >> 2, 3); cs_hi();
    wr(8'h00, 8'h22, 0);
    rd(8'h00, 1, b, df, e);  chk("R11 three edges", b, model[0]);

    // R2 unknown opcode ignored
    wren();
    cs_lo(); shift_out(32'h9F, 4); shift_out(32'h0, 12); shift_out(32'h44, 4); cs_hi();
    wr(8'h00, 8'h33, 0); model[0] = 8'h33;
    rd(8'h00, 1, b, df, e);  chk("R2 unknown opcode", b, 8'h33);

    // R12 abort mid-address then fresh read
    cs_lo(); shift_out(32'hE8, 4); shift_out(32'h0, 5); cs_hi();
    chk("R12 oe after abort", {7'h0, dq_oe}, 8'h00);
    rd(8'h01, 2, b, df, e);
    chk("R12 fresh read", b, model[1]);
    chk("R12 fresh repeat", df, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule